// File: doc/BRIEF.md
# Bit-Offset Field Load/Store Unit

This unit reads and writes fields of 1, 8, 16 or 32 bits that may begin at any bit position in a memory built from 32-bit words. Each request gives a 32-bit word address and a separate 32-bit bit offset. The unit adds the upper offset bits to the word address to find the first word. The low five offset bits give the starting bit inside that word, with bit 0 as the least significant bit. A field that runs past bit 31 of its first word continues into the next word. In that case the unit fetches both words and joins them into a 64-bit window, with the higher-addressed word in the upper half.

A load returns the field right-aligned in a 64-bit result. The upper bits are zeros, or copies of the field's top bit when the request's sign flag is set. A store fetches the word or words that hold the field and replaces only the field bits. It then writes back only the words whose contents actually change. Requests use a valid/ready handshake, and the unit takes one request at a time. A one-cycle done pulse marks the end of each request.

The unit drives a simple single-port synchronous word memory. Read data appears on the cycle after a read is issued.

Top module: `bitfield_lsu`

## Requirements
- R1: The first word accessed is the word address plus the bit offset shifted right by 5, wrapping modulo 2^32. The starting bit is bits [4:0] of the offset.
- R2: The size code selects the field width: 0 gives 1 bit, 1 gives 8 bits, 2 gives 16 bits and 3 gives 32 bits.
- R3: When start bit plus width exceeds 32, the unit reads the first word and then the next word, and treats them as {next, first}. Otherwise it reads exactly one word. No request causes more than two reads.
- R4: With the sign flag clear, a load returns the field in bits [width-1:0] and zeros above.
- R5: With the sign flag set, a load copies field bit width-1 into every result bit above the field.
- R6: A store sets the field bits to the low width bits of the store data and leaves every other bit of every memory word unchanged.
- R7: A store writes a word only if that word's bits under the field mask change. It therefore makes zero, one or two writes, and every write comes after a read.
- R8: `req_ready` is high only while the unit is idle. A request is taken when valid and ready are both high. Changes on the request inputs while the unit is busy do not affect the request in progress.
- R9: `done` is high for exactly one cycle per accepted request. A load result is valid on `load_data` from that cycle until the next load completes.
- R10: After reset the unit is idle: `req_ready` is high, and `done` and `mem_req` are low.
- R11: `mem_we` is asserted only together with `mem_req`. While idle the unit issues no memory cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Field size code (see R2) |
| req_signed | input | 1 | Sign-extend the load result |
| req_waddr | input | 32 | Word address |
| req_boff | input | 32 | Bit offset |
| req_wdata | input | 32 | Store data, field in the low bits |
| done | output | 1 | One-cycle completion pulse |
| load_data | output | 64 | Load result |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read |

## Verification
The assertions check the protocol on every cycle. They cover the single-cycle done pulse, the loss of ready once a request is taken, the silent memory port while idle, and the pairing of write enable with request. They also cover the limit of two reads and two writes per request, and that every write follows a read. Only the bench's sweeps can show the arithmetic. These sweeps show that the right word is addressed for every offset, that straddling fields join correctly, that sign or zero extension is correct, and that a store disturbs no neighbouring bit and skips unchanged words.

// File: rtl/bfl_pkg.sv
// Shared types for the bit-offset field load/store unit.
// Assumes field widths never exceed 32 bits.
package bfl_pkg;

    typedef enum logic [1:0] {
        FS_BIT  = 2'd0,
        FS_BYTE = 2'd1,
        FS_HALF = 2'd2,
        FS_WORD = 2'd3
    } fsize_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_LO,
        ST_RD_HI,
        ST_CAP,
        ST_ACT,
        ST_WR_LO,
        ST_WR_HI,
        ST_FIN
    } lsu_state_e;

    // Field width in bits for a size code.
    function automatic logic [6:0] fsize_bits(fsize_e s);
        case (s)
            FS_BIT:  return 7'd1;
            FS_BYTE: return 7'd8;
            FS_HALF: return 7'd16;
            default: return 7'd32;
        endcase
    endfunction

endpackage

// File: rtl/bfl_addr_gen.sv
// Address generation: turns a word address plus bit offset into the first
// word, the following word, the start bit, the width and a straddle flag.
// Assumes WW is a power of two.
module bfl_addr_gen
    import bfl_pkg::*;
#(
    parameter int AW = 32,
    parameter int OW = 32,
    parameter int WW = 32,
    localparam int SB = $clog2(WW)
) (
    input  logic [AW-1:0] waddr,
    input  logic [OW-1:0] boff,
    input  logic [1:0]    size,
    output logic [AW-1:0] word0,
    output logic [AW-1:0] word1,
    output logic [SB-1:0] start,
    output logic [SB+1:0] width,
    output logic          span
);

    // Combinational split of the offset and straddle test.
    always_comb begin
        word0 = waddr + AW'(boff >> SB);
        word1 = word0 + AW'(1);
        start = boff[SB-1:0];
        width = (SB+2)'(fsize_bits(fsize_e'(size)));
        span  = ({2'b00, start} + width) > (SB+2)'(WW);
    end

endmodule

// File: rtl/bfl_extract.sv
// Field extraction: shifts the two-word window right to the start bit,
// masks to the field width and optionally sign-extends.
// Assumes width is between 1 and WW.
module bfl_extract #(
    parameter int WW = 32,
    parameter int RW = 2 * WW,
    localparam int SB = $clog2(WW)
) (
    input  logic [RW-1:0] window,
    input  logic [SB-1:0] start,
    input  logic [SB+1:0] width,
    input  logic          sign_en,
    output logic [RW-1:0] value
);

    logic [RW-1:0] mask;
    logic [RW-1:0] shifted;

    // Right-align, mask and extend the field.
    always_comb begin
        mask    = (RW'(1) << width) - RW'(1);
        shifted = window >> start;
        value   = shifted & mask;
        if (sign_en && shifted[width - (SB+2)'(1)])
            value = value | ~mask;
    end

endmodule

// File: rtl/bfl_insert.sv
// Field insertion: replaces the masked field bits of the two-word window
// with store data and flags which half of the window changed.
// Assumes width is between 1 and WW.
module bfl_insert #(
    parameter int WW = 32,
    parameter int RW = 2 * WW,
    localparam int SB = $clog2(WW)
) (
    input  logic [RW-1:0] window,
    input  logic [SB-1:0] start,
    input  logic [SB+1:0] width,
    input  logic [WW-1:0] fdata,
    output logic [RW-1:0] merged,
    output logic          chg_lo,
    output logic          chg_hi
);

    logic [RW-1:0] fmask;
    logic [RW-1:0] placed;

    // Build the positioned mask, merge and compare per word.
    always_comb begin
        fmask  = ((RW'(1) << width) - RW'(1)) << start;
        placed = RW'(fdata) << start;
        merged = (window & ~fmask) | (placed & fmask);
        chg_lo = merged[WW-1:0]  != window[WW-1:0];
        chg_hi = merged[RW-1:WW] != window[RW-1:WW];
    end

endmodule

// File: rtl/bitfield_lsu.sv
// Top level of the bit-offset field load/store unit. Takes one request at a
// time, reads one or two words, then returns the field or writes back the
// changed words. Assumes a memory whose read data follows one cycle after
// a read request, and which accepts one access per cycle.
module bitfield_lsu
    import bfl_pkg::*;
#(
    parameter int AW = 32,
    parameter int OW = 32,
    parameter int WW = 32,
    localparam int RW = 2 * WW,
    localparam int SB = $clog2(WW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_store,
    input  logic [1:0]    req_size,
    input  logic          req_signed,
    input  logic [AW-1:0] req_waddr,
    input  logic [OW-1:0] req_boff,
    input  logic [WW-1:0] req_wdata,
    output logic          done,
    output logic [RW-1:0] load_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [WW-1:0] mem_wdata,
    input  logic [WW-1:0] mem_rdata
);

    lsu_state_e    st_q, st_d;
    logic          accept;

    logic [AW-1:0] a_word0, a_word1;
    logic [SB-1:0] a_start;
    logic [SB+1:0] a_width;
    logic          a_span;

    logic          r_store, r_sign, r_span;
    logic [AW-1:0] r_word0, r_word1;
    logic [SB-1:0] r_start;
    logic [SB+1:0] r_width;
    logic [WW-1:0] r_wdata;
    logic [WW-1:0] lo_q, hi_q;
    logic [RW-1:0] win_q;
    logic          wr_hi_q;

    logic [RW-1:0] ext_val, ins_val;
    logic          chg_lo, chg_hi;

    assign req_ready = (st_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign done      = (st_q == ST_FIN);

    bfl_addr_gen #(.AW(AW), .OW(OW), .WW(WW)) u_addr (
        .waddr (req_waddr),
        .boff  (req_boff),
        .size  (req_size),
        .word0 (a_word0),
        .word1 (a_word1),
        .start (a_start),
        .width (a_width),
        .span  (a_span)
    );

    bfl_extract #(.WW(WW), .RW(RW)) u_ext (
        .window  ({hi_q, lo_q}),
        .start   (r_start),
        .width   (r_width),
        .sign_en (r_sign),
        .value   (ext_val)
    );

    bfl_insert #(.WW(WW), .RW(RW)) u_ins (
        .window (win_q_src()),
        .start  (r_start),
        .width  (r_width),
        .fdata  (r_wdata),
        .merged (ins_val),
        .chg_lo (chg_lo),
        .chg_hi (chg_hi)
    );

    // Window presented to the insert stage: the two captured words.
    function automatic logic [RW-1:0] win_q_src();
        return {hi_q, lo_q};
    endfunction

    // Sequence the request through reads, the action step and writes.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:  if (accept) st_d = ST_RD_LO;
            ST_RD_LO: st_d = ST_RD_HI;
            ST_RD_HI: st_d = ST_CAP;
            ST_CAP:   st_d = ST_ACT;
            ST_ACT: begin
                if (!r_store)                     st_d = ST_FIN;
                else if (chg_lo)                  st_d = ST_WR_LO;
                else if (chg_hi && r_span)        st_d = ST_WR_HI;
                else                              st_d = ST_FIN;
            end
            ST_WR_LO: st_d = wr_hi_q ? ST_WR_HI : ST_FIN;
            ST_WR_HI: st_d = ST_FIN;
            default:  st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Latch the decoded request when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_store <= 1'b0;
            r_sign  <= 1'b0;
            r_span  <= 1'b0;
            r_word0 <= '0;
            r_word1 <= '0;
            r_start <= '0;
            r_width <= '0;
            r_wdata <= '0;
        end else if (accept) begin
            r_store <= req_store;
            r_sign  <= req_signed;
            r_span  <= a_span;
            r_word0 <= a_word0;
            r_word1 <= a_word1;
            r_start <= a_start;
            r_width <= a_width;
            r_wdata <= req_wdata;
        end
    end

    // Capture returned read data; the upper word is zero when not straddling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (st_q == ST_RD_HI) begin
            lo_q <= mem_rdata;
        end else if (st_q == ST_CAP) begin
            hi_q <= r_span ? mem_rdata : '0;
        end
    end

    // Action step: hold merged store window and publish load results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q     <= '0;
            wr_hi_q   <= 1'b0;
            load_data <= '0;
        end else if (st_q == ST_ACT) begin
            win_q   <= ins_val;
            wr_hi_q <= chg_hi && r_span;
            if (!r_store) load_data <= ext_val;
        end
    end

    // Drive the word-memory port from the current state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_word0;
        mem_wdata = win_q[WW-1:0];
        case (st_q)
            ST_RD_LO: mem_req = 1'b1;
            ST_RD_HI: begin
                mem_req  = r_span;
                mem_addr = r_word1;
            end
            ST_WR_LO: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_WR_HI: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_word1;
                mem_wdata = win_q[RW-1:WW];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bfl_checker.sv
// Protocol checker for bitfield_lsu, attached by bind. Counts reads and
// writes per request to bound them without deep temporal operators.
module bfl_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic done,
    input logic mem_req,
    input logic mem_we
);

    logic [1:0] rd_cnt;
    logic [1:0] wr_cnt;
    logic       acc;

    assign acc = req_valid && req_ready;

    // Per-request read and write counters, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n || acc) begin
            rd_cnt <= '0;
            wr_cnt <= '0;
        end else if (mem_req) begin
            if (mem_we && wr_cnt != 2'd3)       wr_cnt <= wr_cnt + 2'd1;
            else if (!mem_we && rd_cnt != 2'd3) rd_cnt <= rd_cnt + 2'd1;
        end
    end

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !req_ready);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req && !done));

    a_r11_we_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    a_r3_read_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (rd_cnt < 2'd2));

    a_r7_write_limit: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (wr_cnt < 2'd2));

    a_r7_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (rd_cnt != 2'd0));

endmodule

bind bitfield_lsu bfl_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we)
);

// File: tb/sim_bitfield_lsu.sv
// Sweep bench for bitfield_lsu: every size at every start bit over two
// words, loads and stores, against a 16-word shadow memory.
module sim_bitfield_lsu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_store = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic        req_signed = 1'b0;
    logic [31:0] req_waddr = '0;
    logic [31:0] req_boff = '0;
    logic [31:0] req_wdata = '0;
    logic        done;
    logic [63:0] load_data;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata;

    logic [31:0] mem [16];
    logic [31:0] shadow [16];
    int          rd_total, wr_total;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    bitfield_lsu u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_store(req_store), .req_size(req_size), .req_signed(req_signed),
        .req_waddr(req_waddr), .req_boff(req_boff), .req_wdata(req_wdata),
        .done(done), .load_data(load_data), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] init_word(int i);
        return 32'hC3A5_0F96 ^ (32'h0101_0101 * i) ^ (i << 13);
    endfunction

    // Word memory model with one-cycle read latency and access counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= init_word(i);
            rd_total <= 0;
            wr_total <= 0;
        end else if (mem_req) begin
            if (mem_we) begin
                mem[mem_addr[3:0]] <= mem_wdata;
                wr_total <= wr_total + 1;
            end else begin
                mem_rdata <= mem[mem_addr[3:0]];
                rd_total  <= rd_total + 1;
            end
        end
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic int width_of(logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 8 : (sz == 2'd2) ? 16 : 32;
    endfunction

    // Shadow bit b counted from bit 0 of word w (R1 placement, R3 straddle).
    function automatic logic sbit(int w, int b);
        return shadow[(w + b / 32) & 15][b % 32];
    endfunction

    function automatic logic [31:0] field_now(int w, int b, int wd);
        logic [31:0] v = '0;
        for (int i = 0; i < wd; i++) v[i] = sbit(w, b + i);
        return v;
    endfunction

    // One access: drive, wait for done, then check against the shadow.
    task automatic access(bit st, logic [1:0] sz, bit sg, logic [31:0] wa,
                          logic [31:0] bo, logic [31:0] wd, bit noise);
        int width = width_of(sz);
        int w = int'((wa + (bo >> 5)) & 32'hF);
        int b = int'(bo[4:0]);
        bit span = (b + width) > 32;
        int rd0 = rd_total;
        int wr0 = wr_total;
        bit got = 1'b0;
        logic [63:0] exp;
        logic [31:0] old0, old1;
        int ewr;

        chk("R8 ready while idle", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_store = st; req_size = sz; req_signed = sg;
        req_waddr = wa; req_boff = bo; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        chk("R8 ready low when busy", 64'(req_ready), 64'd0);
        if (noise) begin
            req_store = ~st; req_size = ~sz; req_signed = ~sg;
            req_waddr = wa + 32'd3; req_boff = ~bo; req_wdata = ~wd;
        end else begin
            req_valid = 1'b0;
        end
        for (int c = 0; c < 40; c++) begin
            if (done) begin got = 1'b1; break; end
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk("R9 done seen", 64'(got), 64'd1);

        chk("R3 read count", 64'(rd_total - rd0), span ? 64'd2 : 64'd1);
        if (!st) begin
            exp = '0;
            for (int i = 0; i < width; i++) exp[i] = sbit(w, b + i);
            if (sg && exp[width-1])
                for (int i = width; i < 64; i++) exp[i] = 1'b1;
            chk(sg ? "R5 signed load" : "R4 zero-extended load", load_data, exp);
        end else begin
            old0 = shadow[w];
            old1 = shadow[(w + 1) & 15];
            for (int i = 0; i < width; i++)
                shadow[(w + (b + i) / 32) & 15][(b + i) % 32] = wd[i];
            ewr = int'(old0 != shadow[w]) + int'(span && old1 != shadow[(w + 1) & 15]);
            chk("R7 write count", 64'(wr_total - wr0), 64'(ewr));
            for (int i = 0; i < 16; i++)
                chk("R6 memory image", 64'(mem[i]), 64'(shadow[i]));
        end
        @(negedge clk);
        chk("R9 done one cycle", 64'(done), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) shadow[i] = init_word(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 ready after reset", 64'(req_ready), 64'd1);
        chk("R10 done low after reset", 64'(done), 64'd0);
        chk("R11 no memory cycle idle", 64'(mem_req), 64'd0);

        // Sweep: every size code (R2) at every start bit over two words.
        for (int sz = 0; sz < 4; sz++) begin
            for (int bo = 0; bo < 64; bo++) begin
                int w = (1 + bo / 32) & 15;
                logic [31:0] data = (32'h9E37_79B9 * (bo + 1 + sz * 64)) ^ (bo << 7);
                if (bo % 4 == 3) data = field_now(w, bo % 32, width_of(2'(sz)));
                access(1'b1, 2'(sz), 1'b0, 32'd1, 32'(bo), data, bo % 5 == 0);
                access(1'b0, 2'(sz), bo[0], 32'd1, 32'(bo), 32'd0, bo % 7 == 0);
            end
        end

        // R1: large offset, and wrap of the word address.
        access(1'b1, 2'd3, 1'b0, 32'd2, 32'h1F0, 32'hDEAD_BEEF, 1'b0);
        access(1'b0, 2'd3, 1'b0, 32'd2, 32'h1F0, 32'd0, 1'b0);
        access(1'b1, 2'd2, 1'b0, 32'hFFFF_FFFF, 32'd40, 32'h0000_8001, 1'b0);
        access(1'b0, 2'd2, 1'b1, 32'hFFFF_FFFF, 32'd40, 32'd0, 1'b1);
        access(1'b0, 2'd1, 1'b1, 32'hFFFF_FFFF, 32'd33, 32'd0, 1'b0);

        finished = 1'b1;
        report();
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog actual=hung expected=complete");
            report();
        end
    end

endmodule